// File: doc/BRIEF.md
# Windowed CCD Readout Sequencer

This block produces the digital timing for reading a three-phase CCD through one output amplifier. Every edge sits on a tick grid (one tick every `TICK_DIV` clocks; ten clocks of a 100 MHz clock give the 100 ns grid). For each sensor row it runs a line transfer on the parallel phases. It then hands the row to the serial register through the transfer gate and pulses the line clamp. Rows that fall inside a programmed rectangle are then clocked out column by column.

Columns inside the rectangle get a long correlated-double-sampling slot. That slot resets the output node, clamps, integrates the reference level, holds, dumps the charge through the summing well, integrates the signal level and ends with an ADC start-convert. Columns outside the rectangle are dumped with a short slot that starts no conversion. Rows outside the rectangle, both before it and after it (the flush), get only line transfers. This keeps the low-noise pixel time inside the window while the frame time drops.

A host sets the window inputs and pulses `start`. The window is captured at that moment. `busy` stays high for the frame and `done` holds afterwards. `abort` returns everything to idle. `pixel_valid` and the row and column indices let the downstream logic tag each digitised pixel.

Top module: `ccd_window_sequencer`

## Requirements
- R1: After reset, and whenever the block is idle, every clock and strobe output is low and `busy`, `done` and `pixel_valid` are low.
- R2: Waveforms step once per tick of `TICK_DIV` clocks. The edge that sets `done` comes TICK_DIV*(ROWS*LINE_TICKS + Ny*(Nx*PIX_TICKS + (COLS-Nx)*DUMP_TICKS)) clocks after the edge that samples `start`. Nx and Ny are the window columns and rows that lie on the sensor.
- R3: Every row gets one line transfer. In quarters of LINE_TICKS, `par_clk` bit 0 (P1) is high, then bit 1 (P2), then bit 2 (P3), and in the last quarter `tgate` and `line_clamp` are high. `tgate` therefore rises ROWS times per frame.
- R4: At most one bit of `ser_clk` is high at any time, with S1 on bit 0, S2 on bit 1 and S3 on bit 2, stepping S1, S2, S3. `sum_well` pulses once for each column clocked.
- R5: A full pixel slot is split into eighths: reset gate plus integrator reset (S1), clamp (S1), integrate reference (S2), hold (S2), summing well (S3), hold, integrate signal, hold. `adc_start` is high on its last tick. Each in-window pixel gives exactly one `pixel_valid` clock, which falls inside `adc_start` and `hold`. It carries the absolute `row_idx` and `col_idx`, with rows ascending and columns ascending within a row.
- R6: A column outside the window in a window row uses a DUMP_TICKS slot: S1, S2, S3 in thirds, `sum_well` with S3, `reset_gate` high throughout, and no `adc_start`.
- R7: Rows outside the window get line transfers only, with no serial clock and no summing well. Parallel and serial clocks are never active together.
- R8: `busy` is high from the accepted `start` until the end of the frame. `done` then rises and holds until the next accepted `start` or `abort`.
- R9: A `start` pulse while `busy` is high has no effect.
- R10: After a cycle with `abort` high, all clock and strobe outputs are low and `busy` and `done` are low. When `abort` and `start` arrive in the same cycle, `abort` wins.
- R11: The window is clipped to the sensor edges. A zero width or zero height gives no `pixel_valid`.
- R12: The window inputs are sampled only on the cycle that accepts `start`. Later changes do not affect the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a frame (accepted when idle or done) |
| abort | input | 1 | Synchronous return to idle |
| x_start | input | CW | First window column |
| x_size | input | CW+1 | Window width in columns |
| y_start | input | RW | First window row |
| y_size | input | RW+1 | Window height in rows |
| par_clk | output | 3 | Parallel phases P1..P3 (bit 0 = P1) |
| tgate | output | 1 | Transfer gate |
| line_clamp | output | 1 | Line clamp |
| ser_clk | output | 3 | Serial phases S1..S3 (bit 0 = S1) |
| sum_well | output | 1 | Summing well |
| reset_gate | output | 1 | Output node reset gate |
| int_rst | output | 1 | Integrator reset |
| cds_clamp | output | 1 | Video clamp |
| integ | output | 1 | Integrate |
| hold | output | 1 | Hold |
| adc_start | output | 1 | ADC start convert |
| pixel_valid | output | 1 | One-clock strobe per digitised pixel |
| row_idx | output | RW | Current row |
| col_idx | output | CW | Current column |
| busy | output | 1 | Frame in progress |
| done | output | 1 | Frame finished |

## Verification
Two pairs of control events can fall in the same cycle. The first is `abort` with `start`, which the bench drives together while the block is idle; the pass condition is that `busy` stays low and every output stays quiet. The second is a `start` pulse during a running frame, combined with window inputs scrambled right after acceptance. The bench judges this one by the exact frame length, the `pixel_valid` sequence and the pulse counts on the transfer gate, summing well and start-convert, all computed from the window captured at the accepted `start`.

// File: rtl/ccdseq_pkg.sv
package ccdseq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LINE,
        ST_SCAN,
        ST_DONE
    } seq_state_e;

    typedef struct packed {
        logic [2:0] phase;
        logic       tgate;
        logic       lclamp;
    } par_drive_t;

    typedef struct packed {
        logic [2:0] phase;
        logic       sumwell;
        logic       rgate;
        logic       irst;
        logic       clamp;
        logic       integ;
        logic       hold;
        logic       conv;
    } ser_drive_t;

    function automatic int unsigned cwidth(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

    function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                         input int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

    function automatic logic in_span(input logic [15:0] idx, input logic [15:0] first,
                                     input logic [15:0] size);
        return (idx >= first) && ({1'b0, idx} < ({1'b0, first} + {1'b0, size}));
    endfunction

endpackage

// File: rtl/ccdseq_tick.sv
module ccdseq_tick
    import ccdseq_pkg::*;
#(
    parameter int unsigned DIV = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic tick
);
    localparam int unsigned DW = cwidth(DIV);
    localparam logic [DW-1:0] LAST = DW'(DIV - 1);

    logic [DW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
        end else if (cnt == LAST) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign tick = run && (cnt == LAST);

    AST_TICK_RANGE: assert property (@(posedge clk) disable iff (rst)
        cnt <= LAST); // R2

endmodule

// File: rtl/ccdseq_linewave.sv
module ccdseq_linewave
    import ccdseq_pkg::*;
#(
    parameter int unsigned LINE_TICKS = 1000,
    parameter int unsigned CNTW       = 10
) (
    input  logic            active,
    input  logic [CNTW-1:0] cnt,
    output par_drive_t      drv
);
    localparam int unsigned QT = LINE_TICKS / 4;
    localparam logic [CNTW-1:0] E1 = CNTW'(QT);
    localparam logic [CNTW-1:0] E2 = CNTW'(2 * QT);
    localparam logic [CNTW-1:0] E3 = CNTW'(3 * QT);

    always_comb begin
        drv = '0;
        if (active) begin
            if (cnt < E1) begin
                drv.phase = 3'b001;
            end else if (cnt < E2) begin
                drv.phase = 3'b010;
            end else if (cnt < E3) begin
                drv.phase = 3'b100;
            end else begin
                drv.tgate  = 1'b1;
                drv.lclamp = 1'b1;
            end
        end
    end

endmodule

// File: rtl/ccdseq_pixwave.sv
module ccdseq_pixwave
    import ccdseq_pkg::*;
#(
    parameter int unsigned PIX_TICKS  = 400,
    parameter int unsigned DUMP_TICKS = 10,
    parameter int unsigned CNTW       = 10
) (
    input  logic            active,
    input  logic            full,
    input  logic [CNTW-1:0] cnt,
    output ser_drive_t      drv
);
    localparam int unsigned Q  = PIX_TICKS / 8;
    localparam int unsigned DT = DUMP_TICKS / 3;
    localparam logic [CNTW-1:0] B1 = CNTW'(Q);
    localparam logic [CNTW-1:0] B2 = CNTW'(2 * Q);
    localparam logic [CNTW-1:0] B3 = CNTW'(3 * Q);
    localparam logic [CNTW-1:0] B4 = CNTW'(4 * Q);
    localparam logic [CNTW-1:0] B5 = CNTW'(5 * Q);
    localparam logic [CNTW-1:0] B6 = CNTW'(6 * Q);
    localparam logic [CNTW-1:0] B7 = CNTW'(7 * Q);
    localparam logic [CNTW-1:0] PLAST = CNTW'(PIX_TICKS - 1);
    localparam logic [CNTW-1:0] D1 = CNTW'(DT);
    localparam logic [CNTW-1:0] D2 = CNTW'(2 * DT);

    always_comb begin
        drv = '0;
        if (active && full) begin
            if (cnt < B1) begin
                drv.phase = 3'b001;
                drv.rgate = 1'b1;
                drv.irst  = 1'b1;
            end else if (cnt < B2) begin
                drv.phase = 3'b001;
                drv.clamp = 1'b1;
            end else if (cnt < B3) begin
                drv.phase = 3'b010;
                drv.integ = 1'b1;
            end else if (cnt < B4) begin
                drv.phase = 3'b010;
                drv.hold  = 1'b1;
            end else if (cnt < B5) begin
                drv.phase   = 3'b100;
                drv.sumwell = 1'b1;
            end else if (cnt < B6) begin
                drv.hold = 1'b1;
            end else if (cnt < B7) begin
                drv.integ = 1'b1;
            end else begin
                drv.hold = 1'b1;
                drv.conv = (cnt == PLAST);
            end
        end else if (active) begin
            drv.rgate = 1'b1;
            if (cnt < D1) begin
                drv.phase = 3'b001;
            end else if (cnt < D2) begin
                drv.phase = 3'b010;
            end else begin
                drv.phase   = 3'b100;
                drv.sumwell = 1'b1;
            end
        end
    end

endmodule

// File: rtl/ccd_window_sequencer.sv
module ccd_window_sequencer
    import ccdseq_pkg::*;
#(
    parameter int unsigned COLS       = 1024,
    parameter int unsigned ROWS       = 1024,
    parameter int unsigned TICK_DIV   = 10,
    parameter int unsigned PIX_TICKS  = 400,
    parameter int unsigned LINE_TICKS = 1000,
    parameter int unsigned DUMP_TICKS = 10,
    localparam int unsigned CW = cwidth(COLS),
    localparam int unsigned RW = cwidth(ROWS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          abort,
    input  logic [CW-1:0] x_start,
    input  logic [CW:0]   x_size,
    input  logic [RW-1:0] y_start,
    input  logic [RW:0]   y_size,
    output logic [2:0]    par_clk,
    output logic          tgate,
    output logic          line_clamp,
    output logic [2:0]    ser_clk,
    output logic          sum_well,
    output logic          reset_gate,
    output logic          int_rst,
    output logic          cds_clamp,
    output logic          integ,
    output logic          hold,
    output logic          adc_start,
    output logic          pixel_valid,
    output logic [RW-1:0] row_idx,
    output logic [CW-1:0] col_idx,
    output logic          busy,
    output logic          done
);
    localparam int unsigned CNTW = cwidth(max3(PIX_TICKS, LINE_TICKS, DUMP_TICKS));
    localparam logic [CNTW-1:0] LINE_LAST = CNTW'(LINE_TICKS - 1);
    localparam logic [CNTW-1:0] PIX_LAST  = CNTW'(PIX_TICKS - 1);
    localparam logic [CNTW-1:0] DUMP_LAST = CNTW'(DUMP_TICKS - 1);
    localparam logic [RW-1:0]   ROW_LAST  = RW'(ROWS - 1);
    localparam logic [CW-1:0]   COL_LAST  = CW'(COLS - 1);

    seq_state_e      state;
    logic [RW-1:0]   row;
    logic [CW-1:0]   col;
    logic [CNTW-1:0] cnt;
    logic [CW-1:0]   xs_q;
    logic [CW:0]     xsz_q;
    logic [RW-1:0]   ys_q;
    logic [RW:0]     ysz_q;

    logic       tick;
    logic       row_in;
    logic       col_in;
    logic       slot_last;
    par_drive_t pdrv;
    ser_drive_t sdrv;

    assign busy = (state == ST_LINE) || (state == ST_SCAN);
    assign done = (state == ST_DONE);

    ccdseq_tick #(.DIV(TICK_DIV)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .run  (busy),
        .tick (tick)
    );

    assign row_in = in_span(16'(row), 16'(ys_q), 16'(ysz_q));
    assign col_in = in_span(16'(col), 16'(xs_q), 16'(xsz_q));

    always_comb begin
        if (state == ST_LINE) begin
            slot_last = (cnt == LINE_LAST);
        end else if (col_in) begin
            slot_last = (cnt == PIX_LAST);
        end else begin
            slot_last = (cnt == DUMP_LAST);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            row   <= '0;
            col   <= '0;
            cnt   <= '0;
            xs_q  <= '0;
            xsz_q <= '0;
            ys_q  <= '0;
            ysz_q <= '0;
        end else if (abort) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            unique case (state)
                ST_IDLE, ST_DONE: begin
                    if (start) begin
                        state <= ST_LINE;
                        row   <= '0;
                        col   <= '0;
                        cnt   <= '0;
                        xs_q  <= x_start;
                        xsz_q <= x_size;
                        ys_q  <= y_start;
                        ysz_q <= y_size;
                    end
                end
                ST_LINE: begin
                    if (tick) begin
                        if (slot_last) begin
                            cnt <= '0;
                            if (row_in) begin
                                state <= ST_SCAN;
                                col   <= '0;
                            end else if (row == ROW_LAST) begin
                                state <= ST_DONE;
                            end else begin
                                row <= row + 1'b1;
                            end
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                ST_SCAN: begin
                    if (tick) begin
                        if (slot_last) begin
                            cnt <= '0;
                            if (col == COL_LAST) begin
                                col <= '0;
                                if (row == ROW_LAST) begin
                                    state <= ST_DONE;
                                end else begin
                                    row   <= row + 1'b1;
                                    state <= ST_LINE;
                                end
                            end else begin
                                col <= col + 1'b1;
                            end
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    ccdseq_linewave #(.LINE_TICKS(LINE_TICKS), .CNTW(CNTW)) u_line (
        .active (state == ST_LINE),
        .cnt    (cnt),
        .drv    (pdrv)
    );

    ccdseq_pixwave #(.PIX_TICKS(PIX_TICKS), .DUMP_TICKS(DUMP_TICKS), .CNTW(CNTW)) u_pix (
        .active (state == ST_SCAN),
        .full   (col_in),
        .cnt    (cnt),
        .drv    (sdrv)
    );

    assign par_clk     = pdrv.phase;
    assign tgate       = pdrv.tgate;
    assign line_clamp  = pdrv.lclamp;
    assign ser_clk     = sdrv.phase;
    assign sum_well    = sdrv.sumwell;
    assign reset_gate  = sdrv.rgate;
    assign int_rst     = sdrv.irst;
    assign cds_clamp   = sdrv.clamp;
    assign integ       = sdrv.integ;
    assign hold        = sdrv.hold;
    assign adc_start   = sdrv.conv;
    assign pixel_valid = sdrv.conv && tick;
    assign row_idx     = row;
    assign col_idx     = col;

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (par_clk == 3'b000 && ser_clk == 3'b000 && !adc_start && !tgate)); // R1
    AST_SER_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(ser_clk)); // R4
    AST_PAR_SER_EXCL: assert property (@(posedge clk) disable iff (rst)
        !((|par_clk) && (|ser_clk))); // R7
    AST_PV_CONV: assert property (@(posedge clk) disable iff (rst)
        pixel_valid |-> (adc_start && hold)); // R5
    AST_PV_WINDOW: assert property (@(posedge clk) disable iff (rst)
        pixel_valid |-> (row_in && col_in)); // R11
    AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (rst)
        abort |=> (!busy && !done && par_clk == 3'b000 && ser_clk == 3'b000)); // R10
    AST_DONE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (done && !start && !abort) |=> done); // R8
    AST_WINDOW_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (busy && !abort) |=> ($stable(xs_q) && $stable(ysz_q))); // R12

endmodule

// File: tb/ccd_window_sequencer_tb.sv
`timescale 1ns/1ps
module ccd_window_sequencer_tb;
    localparam int COLS = 8;
    localparam int ROWS = 6;
    localparam int DIV  = 2;
    localparam int PIX  = 16;
    localparam int LINE = 8;
    localparam int DUMP = 3;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic       abort = 1'b0;
    logic [2:0] x_start = '0;
    logic [3:0] x_size = '0;
    logic [2:0] y_start = '0;
    logic [3:0] y_size = '0;
    logic [2:0] par_clk, ser_clk, row_idx, col_idx;
    logic tgate, line_clamp, sum_well, reset_gate, int_rst, cds_clamp;
    logic integ, hold, adc_start, pixel_valid, busy, done;

    int checks = 0;
    int fails  = 0;

    wire [14:0] drive = {par_clk, tgate, line_clamp, ser_clk, sum_well, reset_gate,
                         int_rst, cds_clamp, integ, hold, adc_start};

    ccd_window_sequencer #(
        .COLS(COLS), .ROWS(ROWS), .TICK_DIV(DIV),
        .PIX_TICKS(PIX), .LINE_TICKS(LINE), .DUMP_TICKS(DUMP)
    ) u_dut (
        .clk(clk), .rst(rst), .start(start), .abort(abort),
        .x_start(x_start), .x_size(x_size), .y_start(y_start), .y_size(y_size),
        .par_clk(par_clk), .tgate(tgate), .line_clamp(line_clamp), .ser_clk(ser_clk),
        .sum_well(sum_well), .reset_gate(reset_gate), .int_rst(int_rst),
        .cds_clamp(cds_clamp), .integ(integ), .hold(hold), .adc_start(adc_start),
        .pixel_valid(pixel_valid), .row_idx(row_idx), .col_idx(col_idx),
        .busy(busy), .done(done)
    );

    always #2 clk = ~clk;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int span_count(input int first, input int size, input int lim);
        int n = 0;
        for (int i = 0; i < lim; i++) if (i >= first && i < first + size) n++;
        return n;
    endfunction

    task automatic run_frame(input int xs, input int xsz, input int ys, input int ysz);
        int er[64];
        int ec[64];
        int k = 0;
        int nx, ny, exp_clk, n, npix, nconv, nsw, ntg;
        logic psw, ptg, pconv;
        nx = span_count(xs, xsz, COLS);
        ny = span_count(ys, ysz, ROWS);
        for (int r = 0; r < ROWS; r++)
            for (int c = 0; c < COLS; c++)
                if (r >= ys && r < ys + ysz && c >= xs && c < xs + xsz) begin
                    er[k] = r; ec[k] = c; k++;
                end
        exp_clk = DIV * (ROWS * LINE + ny * (nx * PIX + (COLS - nx) * DUMP));
        @(negedge clk);
        x_start = 3'(xs); x_size = 4'(xsz); y_start = 3'(ys); y_size = 4'(ysz);
        start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        x_start = 3'($urandom); x_size = 4'($urandom);
        y_start = 3'($urandom); y_size = 4'($urandom);
        check(busy && !done, "R8", "busy/done at frame start", {busy, done}, 2);
        n = 0; npix = 0; nconv = 0; nsw = 0; ntg = 0;
        psw = 1'b0; ptg = 1'b0; pconv = 1'b0;
        forever begin
            if (pixel_valid) begin
                if (npix < k)
                    check(row_idx == 3'(er[npix]) && col_idx == 3'(ec[npix]), "R5",
                          "pixel row*100+col", row_idx * 100 + col_idx,
                          er[npix] * 100 + ec[npix]);
                check(adc_start && hold, "R5", "convert/hold at pixel_valid",
                      {adc_start, hold}, 3);
                npix++;
            end
            if (adc_start && !pconv) nconv++;
            if (sum_well && !psw) nsw++;
            if (tgate && !ptg) ntg++;
            pconv = adc_start; psw = sum_well; ptg = tgate;
            if (done) break;
            if (n == 5) start = 1'b1;
            if (n == 6) start = 1'b0;
            if (n > 6000) break;
            @(posedge clk);
            n++;
            @(negedge clk);
        end
        check(n == exp_clk, "R2 R9 R12", "frame clocks", n, exp_clk);
        check(npix == k, "R5 R11", "pixel_valid count", npix, k);
        check(nconv == k, "R6", "adc_start pulses", nconv, k);
        check(nsw == ny * COLS, "R4 R7", "sum_well pulses", nsw, ny * COLS);
        check(ntg == ROWS, "R3", "tgate pulses", ntg, ROWS);
        repeat (3) begin
            @(posedge clk);
            @(negedge clk);
        end
        check(done && !busy && drive == '0, "R8", "done held and quiet",
              {done, busy, drive}, 1 << 16);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL R2 watchdog expired actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd7411));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check(drive == '0 && !busy && !done && !pixel_valid, "R1", "reset state",
              {busy, done, pixel_valid, drive}, 0);

        run_frame(0, 8, 0, 6);   // full frame
        run_frame(6, 5, 4, 5);   // R11 clipped at both far edges
        run_frame(2, 0, 1, 3);   // R11 zero width: dump columns only
        run_frame(7, 1, 5, 1);   // last pixel of the sensor
        run_frame(0, 8, 7, 3);   // R7 window below the sensor: transfers only

        // R10 abort in the middle of a frame
        @(negedge clk);
        x_start = 0; x_size = 8; y_start = 0; y_size = 6; start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        repeat (60) @(posedge clk);
        @(negedge clk);
        abort = 1'b1;
        @(posedge clk);
        @(negedge clk);
        abort = 1'b0;
        check(!busy && !done && drive == '0, "R10", "idle after abort",
              {busy, done, drive}, 0);
        // R10 abort and start together
        @(negedge clk);
        abort = 1'b1; start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        abort = 1'b0; start = 1'b0;
        check(!busy && drive == '0, "R10", "abort wins over start", {busy, drive}, 0);
        repeat (4) @(posedge clk);
        @(negedge clk);
        check(!busy && !done && drive == '0, "R1", "stays idle", {busy, done, drive}, 0);

        for (int i = 0; i < 12; i++)
            run_frame($urandom_range(0, 7), $urandom_range(0, 9),
                      $urandom_range(0, 7), $urandom_range(0, 7));

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule